// File: doc/BRIEF.md
# Five-Source Interrupt Front End

This block sits in front of a small processor core and turns five interrupt request lines into one request to the core. Each request has a vector address, and a flag tells the core whether it must run an acknowledge cycle. Three lines are fixed-vector restart requests (low, middle and high). One is a non-maskable trap. One is a general request whose instruction comes from external hardware after an acknowledge.

Each line has its own trigger rule. The low and middle restart lines are level-sensitive. The high restart line is edge-sensitive, with a pending flop that holds the event. The trap needs a rising edge, and the line must still be high when the trap is taken.

The three restart lines can be masked through a mask write port. That same write can discard a pending high-restart event. A global enable gates every source except the trap. The core accepts the presented request by pulsing `take_i`. The accept clears the global enable and the pending flop of the source that was taken.

Top module: `irq_front_end`

## Requirements
- R1: After reset `irq_o` and `ie_o` are 0 and all three restart masks are set (1), so a restart line raised with the enable set gives no request.
- R2: The low (vector 0x002C) and middle (vector 0x0034) restart lines request only while the line is high, unmasked and `ie_o` is 1; nothing is latched.
- R3: A rising edge on `rq_hi_i` sets a pending flop one cycle later, even while masked or disabled. The pending flop then requests vector 0x003C while unmasked and enabled, after the line has fallen.
- R4: A rising edge on `trap_i` sets a trap pending flop. Trap pending AND `trap_i` high requests vector 0x0024 regardless of masks and `ie_o`. If the line falls before the accept, the pending flop is dropped.
- R5: Priority from highest to lowest is trap, high, middle, low, general. `vec_o` shows the vector of the winner, and `vec_o` is 0 when there is no request.
- R6: `mask_we_i` loads `mask_i`: bit 0 masks low, bit 1 masks middle, bit 2 masks high (1 = masked). The general request is gated by `ie_o` only.
- R7: A general request (`gen_req_i` with `ie_o`=1) that wins sets `need_ack_o`=1 with `vec_o`=0x0000. `need_ack_o` is 0 for every other source.
- R8: `take_i` while `irq_o`=1 clears `ie_o` on the next cycle. If the trap or the high source won, the accept also clears that source's pending flop.
- R9: `mask_we_i` with `mask_clr_hi_i`=1 clears the high pending flop. A new rising edge in the same cycle takes precedence over the clear.
- R10: `ie_set_i` sets `ie_o` on the next cycle and `ie_clr_i` clears it. An accept overrides both, and clear overrides set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_i | input | 1 | Non-maskable trap line |
| rq_hi_i | input | 1 | Edge-sensitive high restart line |
| rq_mid_i | input | 1 | Level-sensitive middle restart line |
| rq_lo_i | input | 1 | Level-sensitive low restart line |
| gen_req_i | input | 1 | General request needing acknowledge |
| mask_we_i | input | 1 | Mask write strobe |
| mask_i | input | 3 | Mask value {hi, mid, lo}, 1 = masked |
| mask_clr_hi_i | input | 1 | With mask_we_i, discard pending high event |
| ie_set_i | input | 1 | Set global enable |
| ie_clr_i | input | 1 | Clear global enable |
| take_i | input | 1 | Core accepts the presented request |
| irq_o | output | 1 | A request is presented |
| vec_o | output | 16 | Vector address of the winning source |
| need_ack_o | output | 1 | Winner needs an external acknowledge cycle |
| ie_o | output | 1 | Global enable state |

## Verification
A stuck or lost pending flop shows up as a wrong `irq_o` or `vec_o` in the cycle after the edge or accept that should have changed it. A high event shows up after its line has fallen; a trap shows up after its line has dropped. A wrong mask or enable state changes `irq_o` in the same cycle that a level line is raised. A wrong enable update appears on `ie_o` one cycle after the accept or the set/clear strobe. The bench compares all four outputs every cycle against a reference model, so such a fault is seen in the first cycle it becomes visible.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int VEC_W   = 16;
  localparam int NUM_SRC = 5;
  localparam int MASK_W  = 3;

  // request index order is priority order, 0 highest
  localparam int IDX_TRAP = 0;
  localparam int IDX_HI   = 1;
  localparam int IDX_MID  = 2;
  localparam int IDX_LO   = 3;
  localparam int IDX_GEN  = 4;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_HI   = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_GEN  = '0;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, rise, hold;

  assign rise = line_i & ~prev_q;

  generate
    if (LEVEL_QUAL) begin : g_lvl
      assign hold = pend_q & ~clr_i & line_i;
    end else begin : g_edge
      assign hold = pend_q & ~clr_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      pend_q <= rise | hold;
    end
  end

  assign pend_o = pend_q;

  a_r3_edge_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_i) |=> pend_o);

  generate
    if (LEVEL_QUAL) begin : g_lvl_chk
      a_r4_drop_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !line_i |=> !pend_o);
    end
  endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == 0) begin : g_top
        assign grant_o[i] = req_i[i];
      end else begin : g_rest
        assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end
  import irq_fe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic              rq_hi_i,
  input  logic              rq_mid_i,
  input  logic              rq_lo_i,
  input  logic              gen_req_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              mask_clr_hi_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              take_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              need_ack_o,
  output logic              ie_o
);
  logic [MASK_W-1:0]  mask_q;
  logic               ie_q;
  logic               trap_pend, hi_pend;
  logic               accept, clr_trap, clr_hi;
  logic [NUM_SRC-1:0] req, grant;

  assign accept   = take_i & irq_o;
  assign clr_trap = accept & grant[IDX_TRAP];
  assign clr_hi   = (accept & grant[IDX_HI]) | (mask_we_i & mask_clr_hi_i);

  irq_edge_latch #(.LEVEL_QUAL(1'b1)) u_trap (
    .clk_i, .rst_ni, .line_i(trap_i), .clr_i(clr_trap), .pend_o(trap_pend)
  );

  irq_edge_latch #(.LEVEL_QUAL(1'b0)) u_hi (
    .clk_i, .rst_ni, .line_i(rq_hi_i), .clr_i(clr_hi), .pend_o(hi_pend)
  );

  assign req[IDX_TRAP] = trap_pend & trap_i;
  assign req[IDX_HI]   = hi_pend   & ~mask_q[2] & ie_q;
  assign req[IDX_MID]  = rq_mid_i  & ~mask_q[1] & ie_q;
  assign req[IDX_LO]   = rq_lo_i   & ~mask_q[0] & ie_q;
  assign req[IDX_GEN]  = gen_req_i & ie_q;

  irq_prio_sel #(.N(NUM_SRC)) u_sel (.req_i(req), .grant_o(grant));

  always_comb begin
    vec_o = '0;
    unique case (1'b1)
      grant[IDX_TRAP]: vec_o = VEC_TRAP;
      grant[IDX_HI]:   vec_o = VEC_HI;
      grant[IDX_MID]:  vec_o = VEC_MID;
      grant[IDX_LO]:   vec_o = VEC_LO;
      grant[IDX_GEN]:  vec_o = VEC_GEN;
      default:         vec_o = '0;
    endcase
  end

  assign irq_o      = |req;
  assign need_ack_o = grant[IDX_GEN];
  assign ie_o       = ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_i;
      if (accept)        ie_q <= 1'b0;
      else if (ie_clr_i) ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
    end
  end

  a_r5_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r8_accept_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && irq_o) |=> !ie_o);
  a_r4_trap_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_pend && trap_i) |-> (irq_o && vec_o == VEC_TRAP && !need_ack_o));
  a_r6_lo_needs_unmask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vec_o == VEC_LO) |-> (!mask_q[0] && ie_o));
  a_r7_ack_only_general: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_ack_o |-> (gen_req_i && ie_o && vec_o == VEC_GEN));
  a_r9_clear_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_we_i && mask_clr_hi_i && !rq_hi_i) |=> !hi_pend);
endmodule

// File: tb/irq_front_end_tb_top.sv
`timescale 1ns/1ps
module irq_front_end_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic trap_i = 0, rq_hi_i = 0, rq_mid_i = 0, rq_lo_i = 0, gen_req_i = 0;
  logic mask_we_i = 0, mask_clr_hi_i = 0, ie_set_i = 0, ie_clr_i = 0, take_i = 0;
  logic [2:0] mask_i = '0;
  logic irq_o, need_ack_o, ie_o;
  logic [15:0] vec_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_front_end dut_i (.clk_i(clk), .rst_ni, .trap_i, .rq_hi_i, .rq_mid_i,
    .rq_lo_i, .gen_req_i, .mask_we_i, .mask_i, .mask_clr_hi_i, .ie_set_i,
    .ie_clr_i, .take_i, .irq_o, .vec_o, .need_ack_o, .ie_o);

  // reference model state
  logic [2:0] m_mask = 3'b111;
  logic m_ie = 0, m_trap = 0, m_hi = 0, p_trap = 0, p_hi = 0;
  logic e_irq, e_ack;
  logic [15:0] e_vec;
  int e_sel;  // 0 trap,1 hi,2 mid,3 lo,4 gen,5 none

  function automatic void model_out();
    e_sel = 5;
    if (m_trap && trap_i)                       e_sel = 0;
    else if (m_hi && !m_mask[2] && m_ie)        e_sel = 1;
    else if (rq_mid_i && !m_mask[1] && m_ie)    e_sel = 2;
    else if (rq_lo_i && !m_mask[0] && m_ie)     e_sel = 3;
    else if (gen_req_i && m_ie)                 e_sel = 4;
    e_irq = (e_sel != 5);
    e_ack = (e_sel == 4);
    case (e_sel)
      0: e_vec = 16'h0024;
      1: e_vec = 16'h003C;
      2: e_vec = 16'h0034;
      3: e_vec = 16'h002C;
      default: e_vec = 16'h0000;
    endcase
  endfunction

  function automatic void model_tick();
    logic acc;
    acc = take_i && e_irq;
    m_trap = (trap_i && !p_trap) || (m_trap && trap_i && !(acc && e_sel == 0));
    m_hi   = (rq_hi_i && !p_hi) ||
             (m_hi && !(acc && e_sel == 1) && !(mask_we_i && mask_clr_hi_i));
    p_trap = trap_i;
    p_hi   = rq_hi_i;
    if (mask_we_i) m_mask = mask_i;
    if (acc) m_ie = 0;
    else if (ie_clr_i) m_ie = 0;
    else if (ie_set_i) m_ie = 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    #1;
    model_out();
    chk({tag, " irq"}, 32'(irq_o), 32'(e_irq));
    chk({tag, " vec"}, 32'(vec_o), 32'(e_vec));
    chk({tag, " ack"}, 32'(need_ack_o), 32'(e_ack));
    chk({tag, " ie"},  32'(ie_o), 32'(m_ie));
    @(posedge clk);
    model_tick();
    @(negedge clk);
    mask_we_i = 0; mask_clr_hi_i = 0; ie_set_i = 0; ie_clr_i = 0; take_i = 0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tags[6];
    tags = '{"R4", "R3", "R2", "R2", "R7", "R6"};
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk("R1 irq after reset", 32'(irq_o), 0);
    chk("R1 ie after reset", 32'(ie_o), 0);
    @(negedge clk);
    // R1: masks set at reset
    ie_set_i = 1; rq_lo_i = 1; step("R10");
    step("R1");
    // R6: unmask all
    mask_we_i = 1; mask_i = 3'b000; step("R6");
    step("R2");
    #1 chk("R2 lo vector", 32'(vec_o), 32'h002C);
    rq_lo_i = 0; step("R2");
    rq_mid_i = 1; step("R2");
    // R3: short pulse on high line
    rq_hi_i = 1; step("R3");
    rq_hi_i = 0; step("R3");
    #1 chk("R3 hi held after line fell", 32'(vec_o), 32'h003C);
    step("R3");
    // R8: accept high
    take_i = 1; step("R8");
    #1 chk("R8 ie cleared by accept", 32'(ie_o), 0);
    step("R8");
    ie_set_i = 1; step("R10");
    #1 chk("R8 hi pending cleared", 32'(vec_o), 32'h0034);
    rq_mid_i = 0;
    // R9: clear via mask write
    rq_hi_i = 1; step("R9");
    rq_hi_i = 0; mask_we_i = 1; mask_i = 3'b000; mask_clr_hi_i = 1; step("R9");
    step("R9");
    #1 chk("R9 hi cleared by mask write", 32'(irq_o), 0);
    // R4: trap with enable off and masks set
    ie_clr_i = 1; mask_we_i = 1; mask_i = 3'b111; step("R10");
    trap_i = 1; step("R4");
    step("R4");
    #1 chk("R4 trap vector with ie=0", 32'(vec_o), 32'h0024);
    trap_i = 0; step("R4");
    #1 chk("R4 trap dropped when line low", 32'(irq_o), 0);
    trap_i = 1; step("R4");
    take_i = 1; step("R4");
    step("R4");
    #1 chk("R4 trap cleared by accept", 32'(irq_o), 0);
    trap_i = 0;
    // R7: general request
    ie_set_i = 1; mask_we_i = 1; mask_i = 3'b000; step("R10");
    gen_req_i = 1; step("R7");
    #1 chk("R7 need_ack", 32'(need_ack_o), 1);
    // R5: everything pending
    rq_lo_i = 1; rq_mid_i = 1; rq_hi_i = 1; trap_i = 1; step("R5");
    step("R5");
    #1 chk("R5 trap highest", 32'(vec_o), 32'h0024);
    trap_i = 0; step("R5");
    #1 chk("R5 hi over mid", 32'(vec_o), 32'h003C);
    // R10: accept beats set
    take_i = 1; ie_set_i = 1; step("R10");
    #1 chk("R10 accept beats set", 32'(ie_o), 0);
    step("R10");
    rq_lo_i = 0; rq_mid_i = 0; rq_hi_i = 0; gen_req_i = 0;
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) trap_i    = ~trap_i;
      if ($urandom_range(7) == 0) rq_hi_i   = ~rq_hi_i;
      if ($urandom_range(7) == 0) rq_mid_i  = ~rq_mid_i;
      if ($urandom_range(7) == 0) rq_lo_i   = ~rq_lo_i;
      if ($urandom_range(7) == 0) gen_req_i = ~gen_req_i;
      take_i   = ($urandom_range(3) == 0);
      ie_set_i = ($urandom_range(2) == 0);
      ie_clr_i = ($urandom_range(15) == 0);
      if ($urandom_range(15) == 0) begin
        mask_we_i = 1;
        mask_i = 3'($urandom_range(7));
        mask_clr_hi_i = 1'($urandom_range(1));
      end
      #1 model_out();
      step(tags[e_sel]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule